// File: doc/BRIEF.md
# Two-Slot Fault Latch and Interrupt Controller

This block collects the fault conditions of a two-slot power controller and holds each cause in a sticky status bit until software clears it. Each slot supplies five supply-input undervoltage flags, a fast overcurrent trip, a slow overcurrent trip and a slot over-temperature flag. A single global over-temperature flag is shared by both slots. A slot records faults only while at least one of its two enable bits is set. A slow overcurrent trip counts as a fault in two cases: it has lasted for a programmable number of cycles, or it occurs while the slot is over temperature.

Software reaches the block through a simple parallel register bus. The write port and the read port have separate addresses, and reads are combinational. A sticky bit is cleared by writing 1 to its position. When a clear and an active cause meet in the same cycle, the cause wins. The block drives a maskable, active-low interrupt, an active-low per-slot thermal fault output, and per-slot shutdown outputs. It also reports main and auxiliary power-good levels and the levels of two general-purpose input pins.

Register map, with 3-bit addresses and 8-bit data:

- Address 0 is the control register of slot 0; address 1 is the same for slot 1.
  - Bits [1:0] are read/write enable bits.
  - Bit 6 is main power-good (read-only).
  - Bit 7 is auxiliary power-good (read-only).
  - All other bits read 0.
- Address 2 is the status register of slot 0; address 3 is the same for slot 1.
  - Bit 0: undervoltage.
  - Bit 1: fast overcurrent.
  - Bit 2: slow overcurrent filter timeout.
  - Bit 3: slow overcurrent while hot.
  - Bit 4: slot over-temperature.
- Address 4 is the common register.
  - Bit 1: global over-temperature.
  - Bit 2: over-temperature seen on an enabled slot.
  - Bit 3: interrupt mask.
  - Bits [5:4]: general-purpose input pins.
- Address 5 holds the slow-filter terminal count of slot 0; address 6 holds it for slot 1.

Top module: `slot_fault_ctrl`

## Requirements
- R1: Status bits [4:0] of a slot latch their causes as follows: bit 0 is any of the five undervoltage flags, bit 1 is the fast trip, bit 2 is the slow-filter timeout, bit 3 is slow trip AND slot hot, and bit 4 is slot hot. A set bit is cleared only by a write of 1 to its position; writing 0 leaves it set.
- R2: A slot's status bits cannot become set while both of its control bits [1:0] are 0.
- R3: With terminal count L in the slot's filter register, status bit 2 is set after the (L+1)-th rising edge of an unbroken slow trip and not before. A deassertion of the trip restarts the count.
- R4: A slow trip while the slot is hot sets status bits 3 and 4 one edge later and drives that slot's fault_n low. Common bit 2 is also set. The other slot's fault_n and shdn are unaffected.
- R5: Global over-temperature sets common bit 1 whatever the enable bits are, and it drives shdn high for both slots.
- R6: The interrupt mask is common bit 3 and resets to 1. irq_n is low exactly when the mask is 0 and any status bit [4:0] or common bit [2:1] is set. It releases once those bits are cleared.
- R7: A write of 1 to a sticky bit whose cause is active in that cycle leaves the bit set.
- R8: shdn[s] is high while any status bit of slot s or common bit 1 is set. It falls only after those bits are cleared with their causes gone.
- R9: Control bit 7 reads 1 when stby_ok is 1 and aux_out_uv is 0. Control bit 6 reads 1 when all four main_out_uv flags of the slot are 0.
- R10: Common bits [5:4] read the levels of gpi[1:0].
- R11: After reset all sticky bits and enables read 0, the mask reads 1, irq_n and fault_n are high, and shdn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| in_uv | input | 2x5 | Supply-input undervoltage flags per slot |
| fast_trip | input | 2 | Fast overcurrent trip per slot |
| slow_trip | input | 2 | Slow overcurrent trip per slot |
| slot_hot | input | 2 | Slot over-temperature per slot |
| glob_hot | input | 1 | Global over-temperature |
| main_out_uv | input | 2x4 | Main output undervoltage flags per slot |
| aux_out_uv | input | 2 | Auxiliary output undervoltage per slot |
| stby_ok | input | 2 | Standby supply present per slot |
| gpi | input | 2 | General-purpose input pins |
| irq_n | output | 1 | Active-low interrupt |
| fault_n | output | 2 | Active-low slot thermal fault |
| shdn | output | 2 | Slot shutdown request |

## Verification
A cause that is present at a rising edge appears in its sticky bit one edge later. irq_n, shdn and fault_n follow the sticky bits combinationally, so they also settle one edge after the cause. The read path and the power-good bits are combinational and are valid in the same cycle as their inputs. The slow-filter bit is the exception: it appears L+1 edges after the trip rises. The bench therefore drives inputs 2 ns after a rising edge and checks 2 ns after the next one. It expects each result at exactly that count of edges. For the filter it checks both one edge before and at the edge where the bit is due.

// File: rtl/slot_fault_pkg.sv
package slot_fault_pkg;
   localparam int NUM_SLOTS  = 2;
   localparam int ADDR_W     = 3;
   localparam int NUM_CAUSE  = 5;
   localparam int CTRL_BASE  = 0;
   localparam int STAT_BASE  = 2;
   localparam int COMMON_ADR = 4;
   localparam int FILT_BASE  = 5;
   localparam int ST_UV      = 0;
   localparam int ST_FAST    = 1;
   localparam int ST_SLOW_TO = 2;
   localparam int ST_SLOW_HT = 3;
   localparam int ST_HOT     = 4;
   localparam int CS_GHOT    = 1;
   localparam int CS_SHOT    = 2;
   localparam int CS_MASK    = 3;
   localparam int CS_GPI     = 4;
   localparam int CT_MAINPG  = 6;
   localparam int CT_AUXPG   = 7;
endpackage

// File: rtl/slot_filter.sv
module slot_filter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trip,
   input  logic [CNT_W-1:0] limit,
   output logic             timeout
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!trip)         cnt_q <= '0;
      else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
   end

   assign timeout = trip && (cnt_q >= limit);

   // R3
   filt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trip |=> !timeout || (limit == '0));
endmodule

// File: rtl/slot_status.sv
module slot_status
   import slot_fault_pkg::*;
#(
   parameter int NUM_UV   = 5,
   parameter int MAIN_OUT = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_any,
   input  logic [NUM_UV-1:0]    in_uv,
   input  logic                 fast_trip,
   input  logic                 slow_trip,
   input  logic                 slow_to,
   input  logic                 hot,
   input  logic [NUM_CAUSE-1:0] clr,
   input  logic [MAIN_OUT-1:0]  main_out_uv,
   input  logic                 aux_out_uv,
   input  logic                 stby_ok,
   output logic [NUM_CAUSE-1:0] stat_q,
   output logic                 main_pg,
   output logic                 aux_pg
);
   logic [NUM_CAUSE-1:0] cause;

   always_comb begin
      cause             = '0;
      cause[ST_UV]      = |in_uv;
      cause[ST_FAST]    = fast_trip;
      cause[ST_SLOW_TO] = slow_to;
      cause[ST_SLOW_HT] = slow_trip && hot;
      cause[ST_HOT]     = hot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr) | (en_any ? cause : '0);
   end

   assign main_pg = ~|main_out_uv;
   assign aux_pg  = stby_ok && !aux_out_uv;

   // R1
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q | $past(clr)) & $past(stat_q)) == $past(stat_q));

   // R2
   enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_any |=> (stat_q & ~$past(stat_q)) == '0);
endmodule

// File: rtl/common_status.sv
module common_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       glob_hot,
   input  logic       slot_hot_en,
   input  logic       wr_sel,
   input  logic [1:0] clr,
   input  logic       mask_in,
   output logic       ghot_q,
   output logic       shot_q,
   output logic       mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ghot_q <= 1'b0;
         shot_q <= 1'b0;
         mask_q <= 1'b1;
      end else begin
         ghot_q <= (ghot_q & ~(wr_sel & clr[0])) | glob_hot;
         shot_q <= (shot_q & ~(wr_sel & clr[1])) | slot_hot_en;
         if (wr_sel) mask_q <= mask_in;
      end
   end

   // R5
   ghot_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      glob_hot |=> ghot_q);

   // R7
   shot_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_hot_en |=> shot_q);
endmodule

// File: rtl/slot_fault_ctrl.sv
module slot_fault_ctrl
   import slot_fault_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter int NUM_UV     = 5,
   parameter int MAIN_OUT   = 4,
   parameter int FILT_RESET = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic [ADDR_W-1:0]                 rd_addr,
   output logic [DATA_W-1:0]                 rd_data,
   input  logic [NUM_SLOTS-1:0][NUM_UV-1:0]  in_uv,
   input  logic [NUM_SLOTS-1:0]              fast_trip,
   input  logic [NUM_SLOTS-1:0]              slow_trip,
   input  logic [NUM_SLOTS-1:0]              slot_hot,
   input  logic                              glob_hot,
   input  logic [NUM_SLOTS-1:0][MAIN_OUT-1:0] main_out_uv,
   input  logic [NUM_SLOTS-1:0]              aux_out_uv,
   input  logic [NUM_SLOTS-1:0]              stby_ok,
   input  logic [1:0]                        gpi,
   output logic                              irq_n,
   output logic [NUM_SLOTS-1:0]              fault_n,
   output logic [NUM_SLOTS-1:0]              shdn
);
   localparam int EN_W = 2;

   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must hold the 8-bit field layout");
      assert (CNT_W >= 1 && CNT_W <= DATA_W) else $error("CNT_W out of range");
      assert (FILT_RESET < (1 << CNT_W)) else $error("FILT_RESET exceeds counter");
   end

   logic [NUM_SLOTS-1:0][EN_W-1:0]      ctrl_en;
   logic [NUM_SLOTS-1:0][CNT_W-1:0]     filt_q;
   logic [NUM_SLOTS-1:0][NUM_CAUSE-1:0] stat;
   logic [NUM_SLOTS-1:0][DATA_W-1:0]    ctrl_rd;
   logic [NUM_SLOTS-1:0]                slot_hot_en;
   logic                                ghot_q, shot_q, mask_q;
   logic                                any_fault;
   logic                                wr_common;

   assign wr_common = wr_en && (wr_addr == ADDR_W'(COMMON_ADR));

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic             en_any, slow_to, main_pg, aux_pg;
      logic             wr_ctrl, wr_stat, wr_filt;
      logic [NUM_CAUSE-1:0] clr;

      assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(CTRL_BASE + s));
      assign wr_stat = wr_en && (wr_addr == ADDR_W'(STAT_BASE + s));
      assign wr_filt = wr_en && (wr_addr == ADDR_W'(FILT_BASE + s));
      assign clr     = wr_stat ? wr_data[NUM_CAUSE-1:0] : '0;
      assign en_any  = |ctrl_en[s];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_en[s] <= '0;
            filt_q[s]  <= CNT_W'(FILT_RESET);
         end else begin
            if (wr_ctrl) ctrl_en[s] <= wr_data[EN_W-1:0];
            if (wr_filt) filt_q[s]  <= wr_data[CNT_W-1:0];
         end
      end

      slot_filter #(.CNT_W(CNT_W)) u_filter (
         .clk     (clk),
         .rst_n   (rst_n),
         .trip    (slow_trip[s]),
         .limit   (filt_q[s]),
         .timeout (slow_to)
      );

      slot_status #(.NUM_UV(NUM_UV), .MAIN_OUT(MAIN_OUT)) u_status (
         .clk         (clk),
         .rst_n       (rst_n),
         .en_any      (en_any),
         .in_uv       (in_uv[s]),
         .fast_trip   (fast_trip[s]),
         .slow_trip   (slow_trip[s]),
         .slow_to     (slow_to),
         .hot         (slot_hot[s]),
         .clr         (clr),
         .main_out_uv (main_out_uv[s]),
         .aux_out_uv  (aux_out_uv[s]),
         .stby_ok     (stby_ok[s]),
         .stat_q      (stat[s]),
         .main_pg     (main_pg),
         .aux_pg      (aux_pg)
      );

      always_comb begin
         ctrl_rd[s]             = '0;
         ctrl_rd[s][EN_W-1:0]   = ctrl_en[s];
         ctrl_rd[s][CT_MAINPG]  = main_pg;
         ctrl_rd[s][CT_AUXPG]   = aux_pg;
      end

      assign slot_hot_en[s] = slot_hot[s] && en_any;
      assign shdn[s]        = (|stat[s]) || ghot_q;
      assign fault_n[s]     = !stat[s][ST_HOT];

      // R8
      shdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (shdn[s] && !wr_en) |=> shdn[s]);
   end

   common_status u_common (
      .clk         (clk),
      .rst_n       (rst_n),
      .glob_hot    (glob_hot),
      .slot_hot_en (|slot_hot_en),
      .wr_sel      (wr_common),
      .clr         (wr_data[CS_SHOT:CS_GHOT]),
      .mask_in     (wr_data[CS_MASK]),
      .ghot_q      (ghot_q),
      .shot_q      (shot_q),
      .mask_q      (mask_q)
   );

   assign any_fault = (|stat) || ghot_q || shot_q;
   assign irq_n     = !(!mask_q && any_fault);

   always_comb begin
      rd_data = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (rd_addr == ADDR_W'(CTRL_BASE + s)) rd_data = ctrl_rd[s];
         if (rd_addr == ADDR_W'(STAT_BASE + s)) rd_data = DATA_W'(stat[s]);
         if (rd_addr == ADDR_W'(FILT_BASE + s)) rd_data = DATA_W'(filt_q[s]);
      end
      if (rd_addr == ADDR_W'(COMMON_ADR)) begin
         rd_data[CS_GHOT]          = ghot_q;
         rd_data[CS_SHOT]          = shot_q;
         rd_data[CS_MASK]          = mask_q;
         rd_data[CS_GPI+1:CS_GPI]  = gpi;
      end
   end

   // R6
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !wr_en) |=> !irq_n);

   // R4
   hot_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_hot[0] && (|ctrl_en[0])) |=> !fault_n[0]);
endmodule

// File: tb/slot_fault_ctrl_bench.sv
module slot_fault_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [1:0][4:0] in_uv = '0;
   logic [1:0] fast_trip = '0, slow_trip = '0, slot_hot = '0;
   logic       glob_hot = 1'b0;
   logic [1:0][3:0] main_out_uv = '1;
   logic [1:0] aux_out_uv = '0, stby_ok = '0;
   logic [1:0] gpi = '0;
   logic       irq_n;
   logic [1:0] fault_n, shdn;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   slot_fault_ctrl u_slot_fault_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .in_uv(in_uv), .fast_trip(fast_trip),
      .slow_trip(slow_trip), .slot_hot(slot_hot), .glob_hot(glob_hot),
      .main_out_uv(main_out_uv), .aux_out_uv(aux_out_uv), .stby_ok(stby_ok),
      .gpi(gpi), .irq_n(irq_n), .fault_n(fault_n), .shdn(shdn)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   function automatic logic [4:0] cause_of(input logic [4:0] uv, input logic f,
                                           input logic sl, input logic h);
      return {h, sl & h, 1'b0, f, |uv};
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [1:0][4:0] es;
      logic [2:1] ecs;
      logic emask;
      logic [1:0][1:0] en;
      void'($urandom(32'd2024));

      step(); step();
      rst_n = 1'b1;
      step();
      // R11 reset state
      rd(3'd0, d); chk("R11 ctrl0", d, 8'h00);
      rd(3'd2, d); chk("R11 stat0", d, 8'h00);
      rd(3'd4, d); chk("R11 common", d, 8'h08);
      chk("R11 irq_n", irq_n, 1'b1);
      chk("R11 shdn", shdn, 2'b00);
      chk("R11 fault_n", fault_n, 2'b11);

      // R2 disabled slot ignores causes
      in_uv[0][3] = 1'b1; fast_trip[1] = 1'b1;
      step(); step();
      rd(3'd2, d); chk("R2 stat0 disabled", d, 8'h00);
      rd(3'd3, d); chk("R2 stat1 disabled", d, 8'h00);
      chk("R2 shdn", shdn, 2'b00);
      fast_trip[1] = 1'b0;

      // R1 latch and R6 masked
      wr(3'd0, 8'h01);
      step();
      rd(3'd2, d); chk("R1 uv latched", d, 8'h01);
      chk("R8 shdn0", shdn, 2'b01);
      chk("R6 masked irq_n", irq_n, 1'b1);
      wr(3'd4, 8'h00);
      chk("R6 unmasked irq_n", irq_n, 1'b0);
      // R7 clear with cause active
      wr(3'd2, 8'h01);
      rd(3'd2, d); chk("R7 set beats clear", d, 8'h01);
      in_uv[0][3] = 1'b0;
      step();
      // R1 write 0 no effect
      wr(3'd2, 8'h00);
      rd(3'd2, d); chk("R1 write0 keeps", d, 8'h01);
      chk("R8 shdn held", shdn, 2'b01);
      wr(3'd2, 8'h01);
      rd(3'd2, d); chk("R1 w1c clears", d, 8'h00);
      chk("R6 irq released", irq_n, 1'b1);
      chk("R8 shdn released", shdn, 2'b00);

      // R3 filter timeout with L=5
      wr(3'd5, 8'd5);
      slow_trip[0] = 1'b1;
      repeat (5) step();
      rd(3'd2, d); chk("R3 not yet", d[2], 1'b0);
      step();
      rd(3'd2, d); chk("R3 timeout", d, 8'h04);
      slow_trip[0] = 1'b0;
      step();
      wr(3'd2, 8'h04);
      slow_trip[0] = 1'b1; repeat (4) step();
      slow_trip[0] = 1'b0; step();
      slow_trip[0] = 1'b1; repeat (4) step();
      rd(3'd2, d); chk("R3 restart", d, 8'h00);
      slow_trip[0] = 1'b0;
      step();

      // R4 slow trip while hot, slot 0 only
      slow_trip[0] = 1'b1; slot_hot[0] = 1'b1;
      step();
      rd(3'd2, d); chk("R4 hot bits", d & 8'h18, 8'h18);
      chk("R4 fault_n", fault_n, 2'b10);
      chk("R4 other slot shdn", shdn[1], 1'b0);
      rd(3'd4, d); chk("R4 common bit2", d[2], 1'b1);
      slow_trip[0] = 1'b0; slot_hot[0] = 1'b0;
      step();
      wr(3'd2, 8'h1F); wr(3'd4, 8'h06);
      chk("R4 fault_n release", fault_n, 2'b11);

      // R5 global over-temperature, slot 1 disabled
      glob_hot = 1'b1; step();
      glob_hot = 1'b0;
      rd(3'd4, d); chk("R5 ot bit", d[1], 1'b1);
      chk("R5 shdn both", shdn, 2'b11);
      wr(3'd4, 8'h02);
      chk("R5 shdn cleared", shdn, 2'b00);

      // R9 power good
      stby_ok[0] = 1'b1; main_out_uv[0] = 4'h0;
      rd(3'd0, d); chk("R9 both good", d, 8'hC1);
      main_out_uv[0] = 4'h4;
      rd(3'd0, d); chk("R9 main bad", d, 8'h81);
      aux_out_uv[0] = 1'b1;
      rd(3'd0, d); chk("R9 aux bad", d, 8'h01);

      // R10 gpi
      gpi = 2'b10;
      rd(3'd4, d); chk("R10 gpi", d[5:4], 2'b10);
      gpi = 2'b01;
      rd(3'd4, d); chk("R10 gpi", d[5:4], 2'b01);

      // random phase: R1 R2 R6 R8 against bench model
      wr(3'd2, 8'h1F); wr(3'd3, 8'h1F); wr(3'd4, 8'h0E);
      es = '0; ecs = '0; emask = 1'b1; en[0] = 2'b01; en[1] = 2'b00;
      for (int i = 0; i < 400; i++) begin
         logic [1:0][4:0] nc;
         logic [1:0][4:0] clr;
         logic [2:1] cclr;
         if (i == 200) begin wr(3'd1, 8'h02); en[1] = 2'b10; end
         for (int s = 0; s < 2; s++) begin
            in_uv[s]     = (($urandom % 8) == 0) ? 5'($urandom) : 5'h0;
            fast_trip[s] = (($urandom % 6) == 0);
            slot_hot[s]  = (($urandom % 10) == 0);
         end
         glob_hot = (($urandom % 40) == 0);
         wr_en   = ($urandom % 2) == 1;
         wr_addr = 3'(2 + ($urandom % 3));
         wr_data = 8'($urandom);
         clr = '0; cclr = '0;
         if (wr_en && wr_addr == 3'd2) clr[0] = wr_data[4:0];
         if (wr_en && wr_addr == 3'd3) clr[1] = wr_data[4:0];
         if (wr_en && wr_addr == 3'd4) cclr = wr_data[2:1];
         for (int s = 0; s < 2; s++) begin
            nc[s] = (|en[s]) ? cause_of(in_uv[s], fast_trip[s], 1'b0, slot_hot[s]) : 5'h0;
            es[s] = (es[s] & ~clr[s]) | nc[s];
         end
         ecs[1] = (ecs[1] & ~cclr[1]) | glob_hot;
         ecs[2] = (ecs[2] & ~cclr[2]) | ((slot_hot[0] & |en[0]) | (slot_hot[1] & |en[1]));
         if (wr_en && wr_addr == 3'd4) emask = wr_data[3];
         step();
         wr_en = 1'b0;
         rd(3'd2, d); chk("R1 rand stat0", d, {3'b0, es[0]});
         rd(3'd3, d); chk("R2 rand stat1", d, {3'b0, es[1]});
         chk("R6 rand irq_n", irq_n, !(!emask && ((|es) || (|ecs))));
         chk("R8 rand shdn", shdn, {(|es[1]) | ecs[1], (|es[0]) | ecs[1]});
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule